// File: doc/BRIEF.md
# Paired-Channel Interrupt and Run Controller

This block holds the interrupt and run state of a multi-channel DMA engine. The channel direction is fixed: even channels move data out (transmit) and odd channels move data in (receive). Channels 2i and 2i+1 form pair i. One start bit and one stop bit control each direction of a pair. The descriptor engine reports each completed descriptor and each error as a one-cycle pulse per channel. A channel that is running latches each pulse into a status register. That status register is replicated once for each interrupt output. Every copy has its own mask, and software clears a copy by writing 1 to the bit it wants cleared.

For each output, the block builds a transmit summary and a receive summary, both indexed by pair. It also keeps a global event register for each output. An interrupt line stays high while any of these three is non-zero. Software reaches all state through one word-addressed register port. Reads are combinational and writes take effect at the next clock edge.

Top module: `adm_irq_ctl`

## Requirements
- R1: After reset every status copy, mask, run flag and global register reads 0, and every interrupt line is low.
- R2: A done pulse on a running channel sets status bit 0 and an error pulse sets status bit 6, in all four per-output copies, at the next clock edge.
- R3: A write to a status copy clears the bits at positions 0 and 6 that are 1 in the data, in that copy only. Bits written 0 are kept. A pulse in the same cycle as a clear of its bit wins, so the bit stays set.
- R4: A stopped channel ignores event pulses. Bits it latched before it stopped remain until software clears them.
- R5: Writing data with bit i set to the transmit start register runs channel 2i, and to the receive start register runs channel 2i+1. The matching stop register stops the same channel. Bits written 0 change nothing. The run flags can be read back, one bit per pair.
- R6: For output o, bit i of the transmit summary is the OR of status AND mask of channel 2i's copy for o. The receive summary uses channel 2i+1 in the same way.
- R7: Interrupt line o is high exactly while output o's transmit summary, receive summary or global register is non-zero.
- R8: A global event pulse on bit k sets bit k of every output's global register. Writing all ones to an output's global register clears that register only, unless a new pulse arrives in the same cycle. Any other written value has no effect.
- R9: Masks and status copies store only bits 0 and 6. All other bits read as 0.
- R10: Word addresses: 0x000 tx start, 0x001 tx stop, 0x002 rx start, 0x003 rx stop, 0x004 tx run flags, 0x005 rx run flags, 0x008+o tx summary, 0x00C+o rx summary, 0x010+o global. A channel status copy is at 0x200+8*ch+o and its mask at 0x204+8*ch+o. Any other address, or a channel at or above the channel count, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| done_evt_i | input | NCH | Descriptor-done pulse per channel |
| err_evt_i | input | NCH | Error pulse per channel |
| glb_evt_i | input | GW | Global event pulses |
| irq_o | output | NOUT | Interrupt output lines |

## Verification
The bench targets the following corner cases:
- **Swapped pairs.** Pair indexing is checked with transmit and receive channels running from different pairs at the same time. A design that swapped the parities, or indexed by channel instead of by pair, would raise the wrong summary bit.
- **Clear against a new event.** A write-1-to-clear meets a new pulse in the same cycle. A design that let the clear win would lose the event.
- **Stopping a channel.** Pulses arrive on a stopped channel that still holds latched bits. A design that gated the stored value rather than the incoming pulse would wipe the old status.
- **Global register writes.** A write that is not all ones goes to the global register and must be ignored. A clear of one output must not reach the others.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int AW       = 10;
  localparam int DW       = 32;
  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 6;

  typedef enum logic [3:0] {
    K_NONE, K_TXSTART, K_TXSTOP, K_RXSTART, K_RXSTOP,
    K_TXRUN, K_RXRUN, K_TXSUM, K_RXSUM, K_GLB, K_STAT, K_MASK
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [5:0] ch;
    logic [1:0] out;
  } dec_t;

  // R10: word address layout
  function automatic dec_t decode(logic [AW-1:0] a);
    dec_t d;
    d.kind = K_NONE;
    d.ch   = a[8:3];
    d.out  = a[1:0];
    if (a[9]) begin
      d.kind = a[2] ? K_MASK : K_STAT;
    end else if (a[8:5] == 4'd0) begin
      case (a[4:2])
        3'b000: case (a[1:0])
                  2'd0: d.kind = K_TXSTART;
                  2'd1: d.kind = K_TXSTOP;
                  2'd2: d.kind = K_RXSTART;
                  default: d.kind = K_RXSTOP;
                endcase
        3'b001: if (a[1:0] == 2'd0) d.kind = K_TXRUN;
                else if (a[1:0] == 2'd1) d.kind = K_RXRUN;
        3'b010: d.kind = K_TXSUM;
        3'b011: d.kind = K_RXSUM;
        3'b100: d.kind = K_GLB;
        default: d.kind = K_NONE;
      endcase
    end
    return d;
  endfunction

  // R9: compress a data word to the two stored status bits {err, done}
  function automatic logic [1:0] pick(logic [DW-1:0] w);
    return {w[ERR_BIT], w[DONE_BIT]};
  endfunction

  function automatic logic [DW-1:0] spread(logic [1:0] b);
    logic [DW-1:0] w;
    w = '0;
    w[DONE_BIT] = b[0];
    w[ERR_BIT]  = b[1];
    return w;
  endfunction
endpackage

// File: rtl/adm_run_ctl.sv
module adm_run_ctl
  import adm_pkg::*;
#(
  parameter int NPAIR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  kind_e            kind_i,
  input  logic [NPAIR-1:0] bits_i,
  output logic [NPAIR-1:0] tx_run_o,
  output logic [NPAIR-1:0] rx_run_o
);
  // R5: start sets, stop clears, zero bits untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_run_o <= '0;
      rx_run_o <= '0;
    end else if (we_i) begin
      case (kind_i)
        K_TXSTART: tx_run_o <= tx_run_o | bits_i;
        K_TXSTOP:  tx_run_o <= tx_run_o & ~bits_i;
        K_RXSTART: rx_run_o <= rx_run_o | bits_i;
        K_RXSTOP:  rx_run_o <= rx_run_o & ~bits_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adm_chan_regs.sv
module adm_chan_regs #(
  parameter int NOUT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 done_i,
  input  logic                 err_i,
  input  logic [NOUT-1:0]      wr_st_i,
  input  logic [NOUT-1:0]      wr_mk_i,
  input  logic [1:0]           wbits_i,
  output logic [NOUT-1:0][1:0] st_o,
  output logic [NOUT-1:0][1:0] mk_o,
  output logic [NOUT-1:0]      hit_o
);
  logic [1:0] ev;
  // R4: gating applies to incoming pulses only
  assign ev = run_i ? {err_i, done_i} : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= '0;
      mk_o <= '0;
    end else begin
      for (int o = 0; o < NOUT; o++) begin
        // R2/R3: clear first, new event wins
        st_o[o] <= (st_o[o] & ~(wr_st_i[o] ? wbits_i : 2'b00)) | ev;
        if (wr_mk_i[o]) mk_o[o] <= wbits_i;
      end
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_hit
    assign hit_o[o] = |(st_o[o] & mk_o[o]);
  end
endmodule

// File: rtl/adm_glb_regs.sv
module adm_glb_regs #(
  parameter int NOUT = 4,
  parameter int GW   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NOUT-1:0]        clr_i,
  input  logic [GW-1:0]          evt_i,
  output logic [NOUT-1:0][GW-1:0] glb_o
);
  // R8: pulses reach every output, clears are per output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_o <= '0;
    end else begin
      for (int o = 0; o < NOUT; o++)
        glb_o[o] <= (clr_i[o] ? '0 : glb_o[o]) | evt_i;
    end
  end
endmodule

// File: rtl/adm_irq_ctl.sv
module adm_irq_ctl
  import adm_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NOUT = 4,
  parameter int GW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic [NCH-1:0]  done_evt_i,
  input  logic [NCH-1:0]  err_evt_i,
  input  logic [GW-1:0]   glb_evt_i,
  output logic [NOUT-1:0] irq_o
);
  localparam int NPAIR = NCH / 2;
  localparam int CW    = $clog2(NCH);
  localparam int OW    = (NOUT > 1) ? $clog2(NOUT) : 1;

  dec_t dec;
  assign dec = decode(reg_addr_i);

  logic [NCH-1:0]                chan_run;
  logic [NPAIR-1:0]              tx_run, rx_run;
  logic [NCH-1:0][NOUT-1:0][1:0] st_q, mk_q;
  logic [NCH-1:0][NOUT-1:0]      hit;
  logic [NOUT-1:0][NPAIR-1:0]    tx_sum, rx_sum;
  logic [NOUT-1:0][GW-1:0]       glb_q;
  logic [NOUT-1:0]               glb_clr;

  adm_run_ctl #(.NPAIR(NPAIR)) u_run (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .kind_i(dec.kind), .bits_i(reg_wdata_i[NPAIR-1:0]),
    .tx_run_o(tx_run), .rx_run_o(rx_run)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NOUT-1:0] wr_st, wr_mk;
    if (c % 2 == 0) begin : g_tx
      assign chan_run[c] = tx_run[c/2];
    end else begin : g_rx
      assign chan_run[c] = rx_run[c/2];
    end
    for (genvar o = 0; o < NOUT; o++) begin : g_wr
      assign wr_st[o] = reg_we_i && dec.kind == K_STAT && dec.ch == 6'(c) && dec.out == 2'(o);
      assign wr_mk[o] = reg_we_i && dec.kind == K_MASK && dec.ch == 6'(c) && dec.out == 2'(o);
    end
    adm_chan_regs #(.NOUT(NOUT)) u_regs (
      .clk_i, .rst_ni,
      .run_i(chan_run[c]), .done_i(done_evt_i[c]), .err_i(err_evt_i[c]),
      .wr_st_i(wr_st), .wr_mk_i(wr_mk), .wbits_i(pick(reg_wdata_i)),
      .st_o(st_q[c]), .mk_o(mk_q[c]), .hit_o(hit[c])
    );
  end

  // R6: pair-indexed summaries
  for (genvar o = 0; o < NOUT; o++) begin : g_sum
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      assign tx_sum[o][i] = hit[2*i][o];
      assign rx_sum[o][i] = hit[2*i+1][o];
    end
    assign glb_clr[o] = reg_we_i && dec.kind == K_GLB && dec.out == 2'(o) && (&reg_wdata_i);
    // R7
    assign irq_o[o] = (|tx_sum[o]) | (|rx_sum[o]) | (|glb_q[o]);
  end

  adm_glb_regs #(.NOUT(NOUT), .GW(GW)) u_glb (
    .clk_i, .rst_ni, .clr_i(glb_clr), .evt_i(glb_evt_i), .glb_o(glb_q)
  );

  logic out_ok, ch_ok;
  assign out_ok = int'(dec.out) < NOUT;
  assign ch_ok  = int'(dec.ch) < NCH;

  always_comb begin
    reg_rdata_o = '0;
    case (dec.kind)
      K_TXRUN: reg_rdata_o = DW'(tx_run);
      K_RXRUN: reg_rdata_o = DW'(rx_run);
      K_TXSUM: if (out_ok) reg_rdata_o = DW'(tx_sum[dec.out[OW-1:0]]);
      K_RXSUM: if (out_ok) reg_rdata_o = DW'(rx_sum[dec.out[OW-1:0]]);
      K_GLB:   if (out_ok) reg_rdata_o = DW'(glb_q[dec.out[OW-1:0]]);
      K_STAT:  if (out_ok && ch_ok) reg_rdata_o = spread(st_q[dec.ch[CW-1:0]][dec.out[OW-1:0]]);
      K_MASK:  if (out_ok && ch_ok) reg_rdata_o = spread(mk_q[dec.ch[CW-1:0]][dec.out[OW-1:0]]);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adm_irq_ctl_chk.sv
module adm_irq_ctl_chk
  import adm_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NOUT = 4,
  parameter int GW   = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          reg_we_i,
  input logic [AW-1:0]                 reg_addr_i,
  input logic [DW-1:0]                 reg_wdata_i,
  input logic [NCH-1:0]                done_evt_i,
  input logic [NCH-1:0]                err_evt_i,
  input logic [GW-1:0]                 glb_evt_i,
  input logic [NOUT-1:0]               irq_o,
  input logic [NCH-1:0]                chan_run,
  input logic [NCH/2-1:0]              tx_run,
  input logic [NCH/2-1:0]              rx_run,
  input logic [NCH-1:0][NOUT-1:0][1:0] st_q,
  input logic [NCH-1:0][NOUT-1:0][1:0] mk_q,
  input logic [NOUT-1:0][GW-1:0]       glb_q
);
  localparam int NPAIR = NCH / 2;
  dec_t cd;
  assign cd = decode(reg_addr_i);

  logic [NOUT-1:0] any_hit;
  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      any_hit[o] = |glb_q[o];
      for (int c = 0; c < NCH; c++)
        any_hit[o] = any_hit[o] | (|(st_q[c][o] & mk_q[c][o]));
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_o
    p_irq_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[o] == any_hit[o]);
    p_glb_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && cd.kind == K_GLB && cd.out == 2'(o) && (&reg_wdata_i) && glb_evt_i == '0)
      |=> glb_q[o] == '0);
    for (genvar c = 0; c < NCH; c++) begin : g_c
      p_done_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chan_run[c] && done_evt_i[c]) |=> st_q[c][o][0]);
      p_done_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q[c][o][0]) |-> $past(chan_run[c] && done_evt_i[c]));
      p_err_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q[c][o][1]) |-> $past(chan_run[c] && err_evt_i[c]));
      p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && cd.kind == K_STAT && cd.ch == 6'(c) && cd.out == 2'(o)
         && reg_wdata_i[DONE_BIT] && !done_evt_i[c]) |=> !st_q[c][o][0]);
    end
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_p
    p_tx_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && cd.kind == K_TXSTART && reg_wdata_i[i]) |=> tx_run[i]);
    p_tx_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && cd.kind == K_TXSTOP && reg_wdata_i[i]) |=> !tx_run[i]);
    p_rx_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && cd.kind == K_RXSTART && reg_wdata_i[i]) |=> rx_run[i]);
    p_rx_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && cd.kind == K_RXSTOP && reg_wdata_i[i]) |=> !rx_run[i]);
  end
endmodule

bind adm_irq_ctl adm_irq_ctl_chk #(.NCH(NCH), .NOUT(NOUT), .GW(GW)) u_chk (.*);

// File: tb/adm_irq_ctl_bench.sv
module adm_irq_ctl_bench;
  localparam int NCH = 8, NOUT = 4, GW = 8, NP = NCH / 2;

  logic            clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [9:0]      addr = '0;
  logic [31:0]     wdata = '0, rdata;
  logic [NCH-1:0]  dn = '0, er = '0;
  logic [GW-1:0]   ge = '0;
  logic [NOUT-1:0] irq;

  always #4 clk = ~clk;

  adm_irq_ctl #(.NCH(NCH), .NOUT(NOUT), .GW(GW)) u_adm_irq_ctl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .done_evt_i(dn),
    .err_evt_i(er), .glb_evt_i(ge), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_st[NOUT][NCH], m_mk[NOUT][NCH], m_glb[NOUT];
  int m_tx = 0, m_rx = 0;

  function automatic int sum_bits(int o, int par);
    int s = 0;
    for (int i = 0; i < NP; i++)
      if ((m_st[o][2*i+par] & m_mk[o][2*i+par]) != 0) s |= (1 << i);
    return s;
  endfunction

  function automatic int model_rd(int a);
    if (a >= 512) begin
      int ch = (a - 512) / 8, o = a % 4;
      if (ch >= NCH) return 0;
      return ((a / 4) % 2 == 1) ? m_mk[o][ch] : m_st[o][ch];
    end
    if (a == 4) return m_tx;
    if (a == 5) return m_rx;
    if (a >= 8 && a < 12) return sum_bits(a - 8, 0);
    if (a >= 12 && a < 16) return sum_bits(a - 12, 1);
    if (a >= 16 && a < 20) return m_glb[a - 16];
    return 0;
  endfunction

  function automatic int model_irq();
    int v = 0;
    for (int o = 0; o < NOUT; o++)
      if (sum_bits(o, 0) != 0 || sum_bits(o, 1) != 0 || m_glb[o] != 0) v |= (1 << o);
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    int n_st[NOUT][NCH], n_mk[NOUT][NCH], n_glb[NOUT];
    int n_tx, n_rx, a;
    a = int'(addr);
    n_tx = m_tx; n_rx = m_rx;
    for (int o = 0; o < NOUT; o++) begin
      for (int c = 0; c < NCH; c++) begin
        bit running = (c % 2 == 0) ? m_tx[c/2] : m_rx[c/2];
        int v = m_st[o][c];
        n_mk[o][c] = m_mk[o][c];
        if (we && a == 512 + 8*c + o) v &= ~(int'(wdata) & 'h41);
        if (we && a == 516 + 8*c + o) n_mk[o][c] = int'(wdata) & 'h41;
        if (running && dn[c]) v |= 1;
        if (running && er[c]) v |= 'h40;
        n_st[o][c] = v;
      end
      n_glb[o] = (we && a == 16 + o && wdata == 32'hFFFF_FFFF) ? 0 : m_glb[o];
      n_glb[o] |= int'(ge);
    end
    if (we) begin
      int b = int'(wdata) & ((1 << NP) - 1);
      if (a == 0) n_tx = m_tx | b;
      if (a == 1) n_tx = m_tx & ~b;
      if (a == 2) n_rx = m_rx | b;
      if (a == 3) n_rx = m_rx & ~b;
    end
    @(posedge clk); #1;
    m_st = n_st; m_mk = n_mk; m_glb = n_glb; m_tx = n_tx; m_rx = n_rx;
    check(int'(irq) == model_irq(), "R7 per-cycle irq", int'(irq), model_irq());
    check(int'(rdata) == model_rd(a), "R10 per-cycle read", int'(rdata), model_rd(a));
    @(negedge clk);
    we = 0; dn = '0; er = '0; ge = '0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = 10'(a); wdata = d; we = 1; tick();
  endtask

  task automatic pulse(logic [NCH-1:0] d, logic [NCH-1:0] e, logic [GW-1:0] g);
    dn = d; er = e; ge = g; tick();
  endtask

  task automatic expect_rd(int a, int exp, string req);
    addr = 10'(a); tick();
    check(int'(rdata) == exp, req, int'(rdata), exp);
  endtask

  task automatic expect_irq(int exp, string req);
    check(int'(irq) == exp, req, int'(irq), exp);
  endtask

  initial begin
    for (int o = 0; o < NOUT; o++) begin
      m_glb[o] = 0;
      for (int c = 0; c < NCH; c++) begin m_st[o][c] = 0; m_mk[o][c] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    expect_rd('h200, 0, "R1 status");
    expect_rd('h004, 0, "R1 run");
    expect_rd('h010, 0, "R1 global");
    expect_irq(0, "R1 irq");
    // R4: stopped channel ignores pulses
    pulse(8'h01, 8'h01, '0);
    expect_rd('h200, 0, "R4 stopped ch0");
    // R5: start tx pair 0 (ch0), rx pair 1 (ch3)
    wr('h000, 32'h1);
    wr('h002, 32'h2);
    expect_rd('h004, 1, "R5 tx run");
    expect_rd('h005, 2, "R5 rx run");
    // R2: events latch into every copy
    pulse(8'h01, 8'h08, '0);
    expect_rd('h200, 1, "R2 ch0 out0");
    expect_rd('h203, 1, "R2 ch0 out3");
    expect_rd('h21A, 'h40, "R2 ch3 out2");
    expect_irq(0, "R6 masked");
    // R9 / R6 / R7
    wr('h205, 32'hFFFF_FFFF);
    expect_rd('h205, 'h41, "R9 mask bits");
    expect_rd('h009, 1, "R6 tx sum out1");
    expect_irq('b0010, "R7 out1");
    wr('h21E, 32'h40);
    expect_rd('h00E, 2, "R6 rx sum out2 pair1");
    expect_irq('b0110, "R7 out1 out2");
    // R3: write-1-to-clear
    wr('h201, 32'h40);
    expect_rd('h201, 1, "R3 zero bit kept");
    wr('h201, 32'h1);
    expect_rd('h201, 0, "R3 cleared");
    expect_rd('h200, 1, "R3 other copy kept");
    expect_irq('b0100, "R7 after clear");
    dn = '0; er = 8'h08; wr('h21A, 32'h40);
    expect_rd('h21A, 'h40, "R3 event wins");
    // R4: stop keeps latched bits, ignores new pulses
    wr('h003, 32'h2);
    expect_rd('h005, 0, "R5 rx stop");
    expect_rd('h004, 1, "R5 tx untouched");
    wr('h21A, 32'h40);
    pulse('0, 8'h08, '0);
    expect_rd('h21A, 0, "R4 ignored after stop");
    expect_rd('h218, 'h40, "R4 latched kept");
    // R8: global register
    pulse('0, '0, 8'h04);
    expect_rd('h010, 4, "R8 out0 set");
    expect_rd('h013, 4, "R8 out3 set");
    expect_irq('b1111, "R7 global");
    wr('h010, 32'h1234);
    expect_rd('h010, 4, "R8 partial write ignored");
    wr('h010, 32'hFFFF_FFFF);
    expect_rd('h010, 0, "R8 cleared");
    expect_rd('h011, 4, "R8 other output kept");
    expect_irq('b1110, "R7 out0 low");
    // R10: channel beyond count
    wr('h248, 32'hFFFF_FFFF);
    expect_rd('h248, 0, "R10 unmapped channel");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule